// File: doc/BRIEF.md
# CCD Line Clamp and Blank Sequencer

This block tracks where a CCD readout currently is. It counts pixel clocks from each line-start strobe and counts line-start strobes from each frame-start strobe. From those two counts it derives three timing outputs. The first is a horizontal blanking pulse covering the vertical charge-shift interval at the head of each line. The second is a blanking flag for every sample that is not an effective image pixel. The third is an optical-black clamp pulse over the trailing black pixels of every line.

The clamp can be suppressed over an inclusive band of line numbers given on two inputs. No other timing changes when the band is in force, so a few lines can be left unclamped without rebuilding the line layout. The sizes of the shift interval, the dummy pixels, the leading and trailing black pixels, the effective pixels and the vertical regions are parameters. All three timing outputs are registered.

Top module: `ccd_line_sequencer`

## Requirements
- R1: The pixel count reads 0 in the clock after a cycle with `hd` high. Otherwise it increments by one per clock and saturates at all ones (255 by default).
- R2: The line count reads 0 in the clock after a cycle with `vd` high. In a cycle with `hd` high and `vd` low it increments by one and saturates at all ones (63 by default). When `vd` and `hd` are high together, `vd` takes priority.
- R3: `hblk` is high for pixel counts below the shift length, which is 0 to 15 by default, and low for all higher counts.
- R4: `pblk` is high for every pixel count outside the effective pixel window, which spans counts 48 to 111 by default. This covers the shift interval, the dummy pixels, both black pixel groups and counts beyond the line end at 160.
- R5: `pblk` is high on every line outside the effective line window, which spans lines 10 to 29 by default. This covers lines 0 to 9, lines 30 and 31, and any line from 32 upward.
- R6: `clpob` is high for pixel counts 112 to 159 (the trailing black pixels) on every line that is not masked, and low for all other counts.
- R7: `clpob` is forced low on lines from `mask_start` through `mask_end`, both ends included. If `mask_start` is greater than `mask_end`, no line is masked.
- R8: `hblk`, `pblk` and `clpob` reflect the pixel and line counts of the previous clock. While reset is asserted, all outputs and both counts read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hd | input | 1 | Line-start strobe, one clock wide |
| vd | input | 1 | Frame-start strobe, one clock wide |
| mask_start | input | LINE_W | First line of the clamp-suppress band |
| mask_end | input | LINE_W | Last line of the clamp-suppress band |
| hblk | output | 1 | Horizontal blanking during the vertical shift interval |
| pblk | output | 1 | Output blanking for non-effective samples |
| clpob | output | 1 | Optical-black clamp pulse |
| pix_cnt | output | PIX_W | Current pixel count within the line |
| line_cnt | output | LINE_W | Current line count within the frame |

## Verification
The assertions assume that `hd` and `vd` are single-clock strobes. Their counter properties assume that nothing other than these strobes moves the counts. They also assume that the mask inputs only change between lines. The stimulus drives every strobe for exactly one clock on a falling edge. It changes the mask values only while a frame is being restarted, and it samples results on falling edges at a count that is computed from the strobe that started the line.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef struct packed {
    logic hblk;
    logic pblk;
    logic clpob;
  } ccd_tim_t;

endpackage

// File: rtl/ccd_sat_counter.sv
module ccd_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (adv && (cnt != CNT_MAX));
    cnt_d  = clr ? '0 : cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/ccd_region_decode.sv
module ccd_region_decode
  import ccd_seq_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int LINE_W     = 6,
  parameter int VSHIFT     = 16,
  parameter int DUMMY      = 28,
  parameter int FRONT_OB   = 4,
  parameter int ACT_PIX    = 64,
  parameter int BACK_OB    = 48,
  parameter int TOP_LINES  = 10,
  parameter int ACT_LINES  = 20
) (
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  input  logic [LINE_W-1:0] mask_lo,
  input  logic [LINE_W-1:0] mask_hi,
  output ccd_tim_t          tim
);

  localparam int EFF_LO_I  = VSHIFT + DUMMY + FRONT_OB;
  localparam int BOB_LO_I  = EFF_LO_I + ACT_PIX;
  localparam int BOB_HI_I  = BOB_LO_I + BACK_OB;

  localparam logic [PIX_W-1:0]  P_SHIFT_END = PIX_W'(VSHIFT);
  localparam logic [PIX_W-1:0]  P_EFF_LO    = PIX_W'(EFF_LO_I);
  localparam logic [PIX_W-1:0]  P_BOB_LO    = PIX_W'(BOB_LO_I);
  localparam logic [PIX_W-1:0]  P_BOB_HI    = PIX_W'(BOB_HI_I);
  localparam logic [LINE_W-1:0] L_EFF_LO    = LINE_W'(TOP_LINES);
  localparam logic [LINE_W-1:0] L_EFF_HI    = LINE_W'(TOP_LINES + ACT_LINES);

  logic eff_pix, eff_line, back_black, band_hit;

  always_comb begin
    eff_pix    = (pix >= P_EFF_LO) && (pix < P_BOB_LO);
    eff_line   = (line >= L_EFF_LO) && (line < L_EFF_HI);
    back_black = (pix >= P_BOB_LO) && (pix < P_BOB_HI);
    band_hit   = (mask_lo <= mask_hi) && (line >= mask_lo) && (line <= mask_hi);

    tim.hblk   = pix < P_SHIFT_END;
    tim.pblk   = !(eff_pix && eff_line);
    tim.clpob  = back_black && !band_hit;
  end

endmodule

// File: rtl/ccd_line_sequencer.sv
module ccd_line_sequencer
  import ccd_seq_pkg::*;
#(
  parameter int VSHIFT      = 16,
  parameter int DUMMY       = 28,
  parameter int FRONT_OB    = 4,
  parameter int ACT_PIX     = 64,
  parameter int BACK_OB     = 48,
  parameter int TOP_LINES   = 10,
  parameter int ACT_LINES   = 20,
  parameter int BOT_LINES   = 2,
  localparam int PIX_END    = VSHIFT + DUMMY + FRONT_OB + ACT_PIX + BACK_OB,
  localparam int LINE_END   = TOP_LINES + ACT_LINES + BOT_LINES,
  localparam int PIX_W      = $clog2(PIX_END + 1),
  localparam int LINE_W     = $clog2(LINE_END + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hd,
  input  logic              vd,
  input  logic [LINE_W-1:0] mask_start,
  input  logic [LINE_W-1:0] mask_end,
  output logic              hblk,
  output logic              pblk,
  output logic              clpob,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt
);

  logic [1:0] rst_pipe;
  logic       rst_q;
  ccd_tim_t   tim_d;
  ccd_tim_t   tim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_q = rst_pipe[1];

  ccd_sat_counter #(.W(PIX_W)) u_pix_ctr (
    .clk   (clk),
    .rst_n (rst_q),
    .clr   (hd),
    .adv   (1'b1),
    .cnt   (pix_cnt)
  );

  ccd_sat_counter #(.W(LINE_W)) u_line_ctr (
    .clk   (clk),
    .rst_n (rst_q),
    .clr   (vd),
    .adv   (hd),
    .cnt   (line_cnt)
  );

  ccd_region_decode #(
    .PIX_W     (PIX_W),
    .LINE_W    (LINE_W),
    .VSHIFT    (VSHIFT),
    .DUMMY     (DUMMY),
    .FRONT_OB  (FRONT_OB),
    .ACT_PIX   (ACT_PIX),
    .BACK_OB   (BACK_OB),
    .TOP_LINES (TOP_LINES),
    .ACT_LINES (ACT_LINES)
  ) u_decode (
    .pix     (pix_cnt),
    .line    (line_cnt),
    .mask_lo (mask_start),
    .mask_hi (mask_end),
    .tim     (tim_d)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      tim_q <= '0;
    end else begin
      tim_q <= tim_d;
    end
  end

  assign hblk  = tim_q.hblk;
  assign pblk  = tim_q.pblk;
  assign clpob = tim_q.clpob;

endmodule

// File: rtl/ccd_line_sequencer_chk.sv
module ccd_line_sequencer_chk #(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hd,
  input logic              vd,
  input logic              hblk,
  input logic              pblk,
  input logic              clpob,
  input logic [PIX_W-1:0]  pix_cnt,
  input logic [LINE_W-1:0] line_cnt
);

  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  p_pix_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hd |=> (pix_cnt == '0));

  p_pix_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hd && pix_cnt != PIX_MAX) |=> (pix_cnt == $past(pix_cnt) + PIX_W'(1)));

  p_pix_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hd && pix_cnt == PIX_MAX) |=> (pix_cnt == PIX_MAX));

  p_line_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vd |=> (line_cnt == '0));

  p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hd && !vd && line_cnt != LINE_MAX) |=> (line_cnt == $past(line_cnt) + LINE_W'(1)));

  p_line_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hd && !vd) |=> $stable(line_cnt));

  p_shift_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hblk |-> pblk);

  p_clamp_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clpob |-> (pblk && !hblk));

endmodule

bind ccd_line_sequencer ccd_line_sequencer_chk #(
  .PIX_W  (PIX_W),
  .LINE_W (LINE_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .hd       (hd),
  .vd       (vd),
  .hblk     (hblk),
  .pblk     (pblk),
  .clpob    (clpob),
  .pix_cnt  (pix_cnt),
  .line_cnt (line_cnt)
);

// File: tb/test_ccd_line_sequencer.sv
`timescale 1ns/1ps
module test_ccd_line_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hd = 1'b0;
  logic       vd = 1'b0;
  logic [5:0] mask_start = '0;
  logic [5:0] mask_end = '0;
  logic       hblk, pblk, clpob;
  logic [7:0] pix_cnt;
  logic [5:0] line_cnt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ccd_line_sequencer i_ccd_line_sequencer (
    .clk(clk), .rst_n(rst_n), .hd(hd), .vd(vd),
    .mask_start(mask_start), .mask_end(mask_end),
    .hblk(hblk), .pblk(pblk), .clpob(clpob),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  typedef struct packed {
    int line; int pix; int ms; int me;
    bit h; bit p; bit c;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{12,   0, 5, 7, 1'b1, 1'b1, 1'b0},  // R3 R4 start of shift
    '{12,  15, 5, 7, 1'b1, 1'b1, 1'b0},  // R3 last shift pixel
    '{12,  16, 5, 7, 1'b0, 1'b1, 1'b0},  // R3 R4 first dummy
    '{12,  47, 5, 7, 1'b0, 1'b1, 1'b0},  // R4 last front black
    '{12,  48, 5, 7, 1'b0, 1'b0, 1'b0},  // R4 first effective
    '{12, 111, 5, 7, 1'b0, 1'b0, 1'b0},  // R4 last effective
    '{12, 112, 5, 7, 1'b0, 1'b1, 1'b1},  // R6 first back black
    '{12, 159, 5, 7, 1'b0, 1'b1, 1'b1},  // R6 last back black
    '{12, 160, 5, 7, 1'b0, 1'b1, 1'b0},  // R4 R6 beyond line end
    '{ 3,  60, 5, 7, 1'b0, 1'b1, 1'b0},  // R5 top black line
    '{ 9,  60, 5, 7, 1'b0, 1'b1, 1'b0},  // R5 last top black line
    '{10,  60, 5, 7, 1'b0, 1'b0, 1'b0},  // R5 first effective line
    '{29,  60, 5, 7, 1'b0, 1'b0, 1'b0},  // R5 last effective line
    '{30,  60, 5, 7, 1'b0, 1'b1, 1'b0},  // R5 bottom black line
    '{ 3, 120, 5, 7, 1'b0, 1'b1, 1'b1},  // R7 outside band
    '{ 5, 120, 5, 7, 1'b0, 1'b1, 1'b0},  // R7 band start inclusive
    '{ 7, 120, 5, 7, 1'b0, 1'b1, 1'b0},  // R7 band end inclusive
    '{ 8, 120, 5, 7, 1'b0, 1'b1, 1'b1},  // R7 just past band
    '{ 6, 120, 9, 4, 1'b0, 1'b1, 1'b1}   // R7 start above end: no mask
  };

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Restart frame (vd with hd), then issue line strobes to reach line L.
  // Returns at the falling edge where outputs reflect pixel count p.
  task automatic go_to(input int L, input int p, input int ms, input int me);
    @(negedge clk);
    mask_start = 6'(ms);
    mask_end   = 6'(me);
    vd = 1'b1;
    hd = 1'b1;
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      vd = 1'b0;
      hd = 1'b0;
      @(negedge clk);
      hd = 1'b1;
    end
    @(negedge clk);
    vd = 1'b0;
    hd = 1'b0;
    repeat (p + 1) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    check("R8 reset hblk", hblk, 0);
    check("R8 reset pblk", pblk, 0);
    check("R8 reset clpob", clpob, 0);
    check("R8 reset pix_cnt", pix_cnt, 0);
    check("R8 reset line_cnt", line_cnt, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      go_to(VECS[k].line, VECS[k].pix, VECS[k].ms, VECS[k].me);
      check($sformatf("R3/R8 hblk vec%0d", k), hblk, VECS[k].h);
      check($sformatf("R4/R5 pblk vec%0d", k), pblk, VECS[k].p);
      check($sformatf("R6/R7 clpob vec%0d", k), clpob, VECS[k].c);
      check($sformatf("R1 pix_cnt vec%0d", k), pix_cnt, VECS[k].pix + 1);
      check($sformatf("R2 line_cnt vec%0d", k), line_cnt, VECS[k].line);
    end

    // R2 vd wins over hd: line 0 after combined strobe
    go_to(0, 5, 5, 7);
    check("R2 vd priority line_cnt", line_cnt, 0);
    check("R3 hblk line 0", hblk, 1);

    // R1 pixel count saturation without a new line strobe
    go_to(12, 300, 5, 7);
    check("R1 pix_cnt saturates", pix_cnt, 255);
    check("R4 pblk past line end", pblk, 1);
    check("R6 clpob past line end", clpob, 0);

    // R2 line count saturation and R5 blank beyond frame
    go_to(70, 60, 5, 7);
    check("R2 line_cnt saturates", line_cnt, 63);
    check("R5 pblk beyond frame", pblk, 1);

    // R8 asynchronous reset returns everything to zero
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 reset again pix_cnt", pix_cnt, 0);
    check("R8 reset again pblk", pblk, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule